// File: doc/BRIEF.md
# Card Reader Channel Transfer Controller

This block runs one punched-card reader on an I/O channel. A read-select command fetches one card from the card source. An optional load check follows. The block then hands the card's 80 columns to the channel one at a time as 6-bit BCD characters, each under a valid/ready handshake. It then holds channel select until the channel disconnects. A control command only feeds a card into the reader buffer, and only when that buffer is empty. A test-ready command reports whether media is present. End-of-file and error conditions are sticky: once set, they refuse later transfers until software clears them.

The card image lives in the card source. The block addresses one column at a time through `col_addr` and reads the 12 punch rows back on `col_hol` in the same cycle. The card source answers each fetch with a status: card loaded, end of file, read error, or no media.

The sequencer has five states:
- IDLE: waits for a command.
- FETCH: a card is requested.
- LOADCHK: the configured load column is probed for a 12-row punch.
- XFER: columns stream to the channel.
- WDISC: waits for the channel to disconnect.

Its transitions are:
- IDLE→FETCH on an accepted read, or on an accepted control when no card is held.
- FETCH→LOADCHK when a card arrives and a load column is configured.
- FETCH→XFER when a card arrives for a read with no load column configured.
- FETCH→IDLE on a fetch failure, or when a control's card arrives.
- LOADCHK→XFER for a read, and LOADCHK→IDLE for a control.
- XFER→WDISC on the last column, on a record-stop column, or on a channel end-of-record or timing error.
- WDISC→IDLE on disconnect.

Top module: `crd_xfer_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `chan_sel`, `chr_valid`, `attn`, `eof_flag` and `err_flag` are all 0.
- R2: A test-ready command (op 2) with `media_att` high answers OK (resp 0) and starts nothing. Without media it is treated as an unsupported command.
- R3: Any command while `busy` is high answers BUSY (resp 1) and does not disturb the transfer in progress.
- R4: A read-select (op 0) answers OK, raises `chan_sel` and fetches a card. It then offers columns 0 to 79 in order on `chr_valid`/`chr_data`, and moves to the next column only in a cycle where `chr_ready` is high.
- R5: `chr_eor` is high only with column 79. Once column 79 is accepted, the block keeps `chan_sel` and `busy` high until `chan_disc` is seen, then drops both.
- R6: A column translates as follows. Rows 12, 11 and 0 map to `col_hol` bits 11, 10 and 9. Rows 1 to 9 map to bits 8 down to 0. The character is {zone[1:0], digit[3:0]}. The zone is 3 for a 12 punch, 2 for an 11 punch, 1 for a 0 punch together with a digit, and 0 otherwise. The digit is the punched row 1 to 9, or 10 for a lone 0 punch, or 0 for a blank column.
- R7: A column with more than one digit-row punch or more than one zone punch is sent as octal 17, sets `err_flag`, and the transfer continues.
- R8: While `eof_flag` or `err_flag` is set, read and control commands answer IOERR (resp 2) and start nothing. A `stat_clr` pulse clears both flags.
- R9: An unsupported command (op 3) answers IOERR and pulses `attn` for one cycle.
- R10: The card source can answer a fetch in three failing ways. End of file (code 1) or no media (code 3) sets `eof_flag`. A read error (code 2) sets `err_flag`. Each of these pulses `attn`, drops `chan_sel`, and returns the block to idle.
- R11: When `load_col` is in 1..80, its column (index `load_col`-1) is probed after the fetch. A 12-row punch there makes a load card. On a load card, every column whose index mod 10 is 9 is sent whole, and every other column is sent with its upper two bits cleared.
- R12: A column whose code is 0x924 sends no character. Instead it pulses `rec_end` and moves to WDISC.
- R13: If `chan_eor_in` or `chan_terr` is high when a character is accepted, no further columns are sent and the block waits for `chan_disc`.
- R14: A control command (op 1) fetches a card only when no card is held, raises no select and sends nothing. A read always discards the held card and fetches a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 read-select, 1 control, 2 test-ready, 3 unsupported |
| cmd_resp | output | 2 | Same-cycle answer: 0 OK, 1 BUSY, 2 IOERR |
| media_att | input | 1 | Media present in the reader |
| stat_clr | input | 1 | Clears sticky EOF and error |
| load_col | input | 7 | Load-check column, 1..80; 0 disables |
| card_req | output | 1 | Card fetch request |
| card_rsp_valid | input | 1 | Card source answer valid |
| card_rsp_code | input | 2 | 0 loaded, 1 EOF, 2 error, 3 no media |
| col_addr | output | 7 | Column index into the card image |
| col_hol | input | 12 | Punch rows of the addressed column |
| chr_valid | output | 1 | Character offered to the channel |
| chr_ready | input | 1 | Channel accepts the character |
| chr_data | output | 6 | BCD character |
| chr_eor | output | 1 | End-of-record marker, with the last column |
| chan_eor_in | input | 1 | Channel ends the record on acceptance |
| chan_terr | input | 1 | Channel timing error on acceptance |
| chan_disc | input | 1 | Channel disconnect |
| rec_end | output | 1 | Record ended early by a record-stop column |
| chan_sel | output | 1 | Channel select held by the reader |
| busy | output | 1 | Operation in progress |
| attn | output | 1 | One-cycle attention pulse |
| eof_flag | output | 1 | Sticky end-of-file |
| err_flag | output | 1 | Sticky error |

## Verification
The hardest state to reach from the ports is a load card, where the zone mask depends on both the column index and the punch found at the probed column. The bench fills the card image from its vector table so that column 4 carries a 12 punch. It then reads the card with the load column set to 5, and again set to 6, and compares every column against the masked and the unmasked expectations. Early endings are reached by making the bench's channel raise a timing error or an end-of-record at a chosen column, and by planting the stop code at column 20. A command issued halfway through a stalled transfer exercises the busy refusal.

// File: rtl/crd_pkg.sv
package crd_pkg;
    localparam int HOL_W = 12;
    localparam int BCD_W = 6;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_CTRL  = 2'd1,
        OP_TEST  = 2'd2,
        OP_OTHER = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RSP_OK    = 2'd0,
        RSP_BUSY  = 2'd1,
        RSP_IOERR = 2'd2,
        RSP_RSVD  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        SRC_OK      = 2'd0,
        SRC_EOF     = 2'd1,
        SRC_ERR     = 2'd2,
        SRC_NOMEDIA = 2'd3
    } src_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOADCHK,
        S_XFER,
        S_WDISC
    } st_e;
endpackage

// File: rtl/crd_hol_xlate.sv
module crd_hol_xlate
    import crd_pkg::*;
#(
    parameter logic [HOL_W-1:0] STOP_CODE = 12'h924,
    parameter logic [BCD_W-1:0] BAD_CODE  = 6'o17
) (
    input  logic [HOL_W-1:0] hol,
    output logic [BCD_W-1:0] bcd,
    output logic             bad,
    output logic             stop
);
    logic [8:0] drow;
    logic [3:0] digit;
    logic [1:0] zone;
    int         ndig;
    int         nzone;

    assign drow = hol[8:0];
    assign stop = (hol == STOP_CODE);

    always_comb begin
        digit = 4'd0;
        for (int n = 1; n <= 9; n++) begin
            if (drow[9-n]) digit = 4'(n);
        end
        if (drow == '0 && hol[9]) digit = 4'd10;
        if (hol[11])                     zone = 2'd3;
        else if (hol[10])                zone = 2'd2;
        else if (hol[9] && drow != '0)   zone = 2'd1;
        else                             zone = 2'd0;
        ndig  = $countones(drow);
        nzone = int'(hol[11]) + int'(hol[10]) + int'(hol[9] && drow != '0);
        bad   = !stop && (ndig > 1 || nzone > 1);
        bcd   = bad ? BAD_CODE : {zone, digit};
    end
endmodule

// File: rtl/crd_col_track.sv
module crd_col_track #(
    parameter int NCOL        = 80,
    parameter int ZONE_PERIOD = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    adv,
    output logic [$clog2(NCOL)-1:0] col,
    output logic                    last,
    output logic                    keep_zone
);
    localparam int CW = $clog2(NCOL);
    localparam int PW = $clog2(ZONE_PERIOD);

    logic [CW-1:0] col_q;
    logic [PW-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            ph_q  <= '0;
        end else if (clr) begin
            col_q <= '0;
            ph_q  <= '0;
        end else if (adv) begin
            col_q <= col_q + 1'b1;
            ph_q  <= (ph_q == PW'(ZONE_PERIOD - 1)) ? '0 : ph_q + 1'b1;
        end
    end

    assign col       = col_q;
    assign last      = (col_q == CW'(NCOL - 1));
    assign keep_zone = (ph_q == PW'(ZONE_PERIOD - 1));
endmodule

// File: rtl/crd_seq.sv
module crd_seq
    import crd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic [1:0] cmd_resp,
    input  logic       media_att,
    input  logic       stat_clr,
    input  logic       load_en,
    input  logic       src_valid,
    input  logic [1:0] src_code,
    input  logic       chr_ready,
    input  logic       chan_eor_in,
    input  logic       chan_terr,
    input  logic       chan_disc,
    input  logic       col_last,
    input  logic       col_stop,
    input  logic       col_bad,
    input  logic       ld_punch,
    output logic       card_req,
    output logic       chr_valid,
    output logic       col_clr,
    output logic       col_adv,
    output logic       ld_chk,
    output logic       load_card,
    output logic       rec_end,
    output logic       attn,
    output logic       chan_sel,
    output logic       busy,
    output logic       eof_flag,
    output logic       err_flag
);
    st_e  st_q, st_d;
    rsp_e resp;
    op_e  op;
    src_e code;
    logic eof_q, err_q, held_q, nox_q, sel_q, attn_q, ldc_q;
    logic go_rd, go_ct, bad_op;
    logic got_card, got_eof, got_err, accept, stop_rec;

    assign op   = op_e'(cmd_op);
    assign code = src_e'(src_code);

    // command decode: busy first, then test-ready, then sticky status, then op
    always_comb begin
        resp   = RSP_OK;
        go_rd  = 1'b0;
        go_ct  = 1'b0;
        bad_op = 1'b0;
        if (cmd_valid) begin
            if (st_q != S_IDLE)                resp = RSP_BUSY;
            else if (op == OP_TEST && media_att) resp = RSP_OK;
            else if (eof_q || err_q)           resp = RSP_IOERR;
            else if (op == OP_READ)            go_rd = 1'b1;
            else if (op == OP_CTRL)            go_ct = 1'b1;
            else begin
                resp   = RSP_IOERR;
                bad_op = 1'b1;
            end
        end
    end

    assign got_card = (st_q == S_FETCH) && src_valid && (code == SRC_OK);
    assign got_eof  = (st_q == S_FETCH) && src_valid &&
                      (code == SRC_EOF || code == SRC_NOMEDIA);
    assign got_err  = (st_q == S_FETCH) && src_valid && (code == SRC_ERR);
    assign stop_rec = (st_q == S_XFER) && col_stop;
    assign accept   = (st_q == S_XFER) && !col_stop && chr_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (go_rd || (go_ct && !held_q)) st_d = S_FETCH;
            end
            S_FETCH: begin
                if (got_card) begin
                    if (load_en)    st_d = S_LOADCHK;
                    else if (nox_q) st_d = S_IDLE;
                    else            st_d = S_XFER;
                end else if (got_eof || got_err) begin
                    st_d = S_IDLE;
                end
            end
            S_LOADCHK: st_d = nox_q ? S_IDLE : S_XFER;
            S_XFER: begin
                if (stop_rec) st_d = S_WDISC;
                else if (accept && (col_last || chan_eor_in || chan_terr))
                    st_d = S_WDISC;
            end
            S_WDISC: begin
                if (chan_disc) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // status and bookkeeping flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eof_q  <= 1'b0;
            err_q  <= 1'b0;
            held_q <= 1'b0;
            nox_q  <= 1'b0;
            sel_q  <= 1'b0;
            attn_q <= 1'b0;
            ldc_q  <= 1'b0;
        end else begin
            attn_q <= bad_op || got_eof || got_err;
            if (stat_clr)     eof_q <= 1'b0;
            else if (got_eof) eof_q <= 1'b1;
            if (stat_clr)                        err_q <= 1'b0;
            else if (got_err || (accept && col_bad)) err_q <= 1'b1;
            if (go_rd)         held_q <= 1'b0;
            else if (got_card) held_q <= 1'b1;
            if (go_rd)      nox_q <= 1'b0;
            else if (go_ct) nox_q <= 1'b1;
            if (go_rd) sel_q <= 1'b1;
            else if (got_eof || got_err || (st_q == S_WDISC && chan_disc))
                sel_q <= 1'b0;
            if (go_rd || go_ct)          ldc_q <= 1'b0;
            else if (st_q == S_LOADCHK)  ldc_q <= ld_punch;
        end
    end

    // outputs
    always_comb begin
        cmd_resp  = resp;
        card_req  = (st_q == S_FETCH);
        chr_valid = (st_q == S_XFER) && !col_stop;
        col_adv   = accept;
        col_clr   = (st_q == S_FETCH);
        ld_chk    = (st_q == S_LOADCHK);
        rec_end   = stop_rec;
        busy      = (st_q != S_IDLE);
        attn      = attn_q;
        chan_sel  = sel_q;
        eof_flag  = eof_q;
        err_flag  = err_q;
        load_card = ldc_q;
    end

    a_r8_eof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        eof_q && !stat_clr |=> eof_q)
        else $error("R8 eof flag lost");
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !stat_clr |=> err_q)
        else $error("R8 error flag lost");
    a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == S_XFER && cmd_valid |=> st_q != S_FETCH)
        else $error("R3 command restarted a transfer");
    a_r10_eof_stop: assert property (@(posedge clk) disable iff (!rst_n)
        got_eof |=> !sel_q && st_q == S_IDLE && eof_q)
        else $error("R10 eof did not stop the reader");
    a_r12_stop_wait: assert property (@(posedge clk) disable iff (!rst_n)
        stop_rec |=> st_q == S_WDISC && sel_q)
        else $error("R12 record stop did not wait");
endmodule

// File: rtl/crd_xfer_ctrl.sv
module crd_xfer_ctrl
    import crd_pkg::*;
#(
    parameter int               NCOL        = 80,
    parameter int               ZONE_PERIOD = 10,
    parameter logic [HOL_W-1:0] STOP_CODE   = 12'h924
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [1:0]                cmd_op,
    output logic [1:0]                cmd_resp,
    input  logic                      media_att,
    input  logic                      stat_clr,
    input  logic [$clog2(NCOL+1)-1:0] load_col,
    output logic                      card_req,
    input  logic                      card_rsp_valid,
    input  logic [1:0]                card_rsp_code,
    output logic [$clog2(NCOL)-1:0]   col_addr,
    input  logic [HOL_W-1:0]          col_hol,
    output logic                      chr_valid,
    input  logic                      chr_ready,
    output logic [BCD_W-1:0]          chr_data,
    output logic                      chr_eor,
    input  logic                      chan_eor_in,
    input  logic                      chan_terr,
    input  logic                      chan_disc,
    output logic                      rec_end,
    output logic                      chan_sel,
    output logic                      busy,
    output logic                      attn,
    output logic                      eof_flag,
    output logic                      err_flag
);
    localparam int CW = $clog2(NCOL);
    localparam int LW = $clog2(NCOL + 1);

    logic [CW-1:0]    col;
    logic [BCD_W-1:0] bcd;
    logic col_last, keep_zone, col_bad, col_stop;
    logic col_clr, col_adv, ld_chk, load_card, load_en;

    assign load_en  = (load_col != '0) && (int'(load_col) <= NCOL);
    assign col_addr = ld_chk ? CW'(load_col - LW'(1)) : col;

    crd_col_track #(.NCOL(NCOL), .ZONE_PERIOD(ZONE_PERIOD)) u_track (
        .clk(clk), .rst_n(rst_n), .clr(col_clr), .adv(col_adv),
        .col(col), .last(col_last), .keep_zone(keep_zone)
    );

    crd_hol_xlate #(.STOP_CODE(STOP_CODE)) u_xlate (
        .hol(col_hol), .bcd(bcd), .bad(col_bad), .stop(col_stop)
    );

    crd_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_resp(cmd_resp),
        .media_att(media_att), .stat_clr(stat_clr), .load_en(load_en),
        .src_valid(card_rsp_valid), .src_code(card_rsp_code),
        .chr_ready(chr_ready), .chan_eor_in(chan_eor_in),
        .chan_terr(chan_terr), .chan_disc(chan_disc),
        .col_last(col_last), .col_stop(col_stop), .col_bad(col_bad),
        .ld_punch(col_hol[HOL_W-1]),
        .card_req(card_req), .chr_valid(chr_valid),
        .col_clr(col_clr), .col_adv(col_adv), .ld_chk(ld_chk),
        .load_card(load_card), .rec_end(rec_end), .attn(attn),
        .chan_sel(chan_sel), .busy(busy),
        .eof_flag(eof_flag), .err_flag(err_flag)
    );

    // load card: zone bits survive only on the period's last column
    assign chr_data = (load_card && !keep_zone) ? {2'b00, bcd[3:0]} : bcd;
    assign chr_eor  = chr_valid && col_last;

    a_r5_eor_last: assert property (@(posedge clk) disable iff (!rst_n)
        chr_eor |-> chr_valid && col_addr == CW'(NCOL - 1))
        else $error("R5 eor away from last column");
    a_r4_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid |-> chan_sel)
        else $error("R4 character without select");
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        chr_valid && !chr_ready && !chan_eor_in && !chan_terr
        |=> $stable(col_addr))
        else $error("R4 column moved without acceptance");
endmodule

// File: tb/crd_xfer_ctrl_tb.sv
module crd_xfer_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_resp;
    logic        media_att = 1'b1;
    logic        stat_clr = 1'b0;
    logic [6:0]  load_col = 7'd0;
    logic        card_req, card_rsp_valid;
    logic [1:0]  card_rsp_code;
    logic [6:0]  col_addr;
    logic [11:0] col_hol;
    logic        chr_valid, chr_ready, chr_eor;
    logic [5:0]  chr_data;
    logic        chan_eor_in, chan_terr;
    logic        chan_disc = 1'b0;
    logic        rec_end, chan_sel, busy, attn, eof_flag, err_flag;

    // {column punches, expected character}
    localparam logic [17:0] VEC [0:7] = '{
        {12'h000, 6'h00}, {12'h100, 6'h01}, {12'h001, 6'h09}, {12'h200, 6'h0A},
        {12'h840, 6'h33}, {12'h410, 6'h25}, {12'h280, 6'h12}, {12'h180, 6'o17}
    };

    logic [11:0] card [0:79];
    logic [1:0]  src_code = 2'd0;
    logic        stall = 1'b0;
    int          terr_col = -1, eorin_col = -1;
    int unsigned cyc = 0;
    logic [5:0]  rx [0:79];
    logic        rx_eor [0:79];
    int          rx_n = 0, attn_n = 0, req_n = 0, rend_n = 0;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    assign card_rsp_valid = card_req;
    assign card_rsp_code  = src_code;
    assign col_hol        = (int'(col_addr) < 80) ? card[col_addr] : 12'h000;
    assign chr_ready      = stall ? cyc[0] : 1'b1;
    assign chan_terr      = chr_valid && (int'(col_addr) == terr_col);
    assign chan_eor_in    = chr_valid && (int'(col_addr) == eorin_col);

    crd_xfer_ctrl u_dut (.*);

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (chr_valid && chr_ready && rx_n < 80) begin
            rx[rx_n]     <= chr_data;
            rx_eor[rx_n] <= chr_eor;
            rx_n         <= rx_n + 1;
        end
        if (attn)     attn_n <= attn_n + 1;
        if (card_req) req_n  <= req_n + 1;
        if (rec_end)  rend_n <= rend_n + 1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        summary();
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [1:0] exp, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        #1 chk(cmd_resp == exp, tag, cmd_resp, exp);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic fill(input int ntab);
        for (int c = 0; c < 80; c++) card[c] = VEC[c % ntab][17:6];
    endtask

    // runs a read to the disconnect wait, then disconnects
    task automatic run_read(input int ntab, input bit ld, input int exp_n,
                            input bit probe, input string tag);
        int bad = 0, eor_n = 0, eor_at = -1;
        bit waiting = 0, probed = 0;
        @(negedge clk); rx_n = 0;
        cmd(2'd0, 2'd0, {tag, " R4 read accepted"});
        for (int k = 0; k < 2000 && !waiting; k++) begin
            @(negedge clk);
            if (cmd_valid) cmd_valid = 1'b0;
            #1;
            if (probe && !probed && rx_n >= 5) begin
                probed = 1;
                cmd_valid = 1'b1; cmd_op = 2'd0;
                #1 chk(cmd_resp == 2'd1, "R3 busy answer", cmd_resp, 1);
            end
            if (busy && chan_sel && !chr_valid && !card_req && !rec_end &&
                !cmd_valid && (rx_n > 0 || rend_n > 0)) waiting = 1;
        end
        chk(waiting, {tag, " R5 reached disconnect wait"}, waiting, 1);
        repeat (3) @(negedge clk);
        chk(chan_sel && busy, {tag, " R5 select held until disconnect"},
            {chan_sel, busy}, 3);
        chan_disc = 1'b1;
        @(negedge clk);
        chan_disc = 1'b0;
        #1 chk(!chan_sel && !busy, {tag, " R5 released on disconnect"},
               {chan_sel, busy}, 0);
        chk(rx_n == exp_n, {tag, " R4 character count"}, rx_n, exp_n);
        for (int c = 0; c < rx_n; c++) begin
            logic [5:0] e = VEC[c % ntab][5:0];
            if (ld && (c % 10) != 9) e = e & 6'h0F;
            if (rx[c] !== e) bad++;
            if (rx_eor[c]) begin eor_n++; eor_at = c; end
        end
        chk(bad == 0, {tag, ld ? " R11 load data" : " R6 data"}, bad, 0);
        if (exp_n == 80)
            chk(eor_n == 1 && eor_at == 79, {tag, " R5 eor on column 79"}, eor_at, 79);
        else
            chk(eor_n == 0, {tag, " R13 no eor before stop"}, eor_n, 0);
    endtask

    initial begin
        int a0, r0;
        fill(7);
        repeat (3) @(negedge clk);
        #1 chk(!busy && !chan_sel && !chr_valid && !attn && !eof_flag && !err_flag,
               "R1 reset state", {busy, chan_sel, chr_valid, attn, eof_flag, err_flag}, 0);
        rst_n = 1'b1;

        r0 = req_n;
        cmd(2'd2, 2'd0, "R2 test-ready with media");
        #1 chk(!busy && req_n == r0, "R2 test-ready starts nothing", req_n - r0, 0);

        run_read(7, 0, 80, 0, "plain");
        chk(!err_flag, "R6 no error on valid card", err_flag, 0);
        stall = 1'b1;
        run_read(7, 0, 80, 1, "stalled");
        stall = 1'b0;

        load_col = 7'd5;
        run_read(7, 1, 80, 0, "loadcard");
        load_col = 7'd6;
        run_read(7, 0, 80, 0, "noload");
        load_col = 7'd0;

        terr_col = 10;
        run_read(7, 0, 11, 0, "terr");
        terr_col = -1; eorin_col = 30;
        run_read(7, 0, 31, 0, "chan eor");
        eorin_col = -1;

        rend_n = 0;
        card[20] = 12'h924;
        run_read(7, 0, 20, 0, "stop");
        chk(rend_n == 1, "R12 rec_end pulse", rend_n, 1);
        fill(7);

        fill(8);
        run_read(8, 0, 80, 0, "badpunch");
        chk(err_flag, "R7 error flag set", err_flag, 1);
        cmd(2'd0, 2'd2, "R8 read refused after error");
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        #1 chk(!err_flag, "R8 clear", err_flag, 0);
        fill(7);

        a0 = attn_n; src_code = 2'd1;
        cmd(2'd0, 2'd0, "R10 read before eof");
        repeat (3) @(negedge clk);
        #1 chk(eof_flag && !busy && !chan_sel && attn_n == a0 + 1,
               "R10 eof stops reader", {eof_flag, busy, chan_sel}, 4);
        cmd(2'd1, 2'd2, "R8 control refused at eof");
        cmd(2'd2, 2'd0, "R2 test-ready at eof");
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;

        a0 = attn_n; src_code = 2'd2;
        cmd(2'd0, 2'd0, "R10 read before error");
        repeat (3) @(negedge clk);
        #1 chk(err_flag && !eof_flag && !busy && attn_n == a0 + 1,
               "R10 source error", {err_flag, eof_flag, busy}, 4);
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
        src_code = 2'd0;

        r0 = req_n;
        cmd(2'd1, 2'd0, "R14 control feeds");
        repeat (4) @(negedge clk);
        #1 chk(req_n == r0 + 1 && !busy && !chan_sel && rx_n == 0 || req_n == r0 + 1 && !busy && !chan_sel,
               "R14 control fetch once", req_n - r0, 1);
        r0 = req_n;
        cmd(2'd1, 2'd0, "R14 control when held");
        repeat (3) @(negedge clk);
        #1 chk(req_n == r0 && !busy, "R14 no second fetch", req_n - r0, 0);
        run_read(7, 0, 80, 0, "after control");
        chk(req_n == r0 + 1, "R14 read fetches anew", req_n - r0, 1);

        a0 = attn_n;
        cmd(2'd3, 2'd2, "R9 unsupported op");
        #1 chk(attn_n == a0 + 1, "R9 attention", attn_n - a0, 1);
        media_att = 1'b0; a0 = attn_n;
        cmd(2'd2, 2'd2, "R2 test-ready without media");
        #1 chk(attn_n == a0 + 1 && !busy, "R2 no-media attention", attn_n - a0, 1);
        media_att = 1'b1;

        summary();
    end
endmodule